// File: doc/BRIEF.md
# Signature and Pattern Store Controller with Security Lock

This block guards the configuration memory of a programmable device. It keeps a 32-bit user signature and a small pattern store of `DEPTH` words of `WIDTH` bits. A host issues one command at a time over a valid/busy handshake: write the signature, start a signature readout, program a pattern word, verify (read) a pattern word, set the security lock, or erase the whole device. The signature leaves the block serially, least significant bit first, in the manner of a boundary-scan user-code shift.

The lock protects only the pattern. Once it is set, any pattern program or verify is refused: an error pulse is raised and the returned data is zero. The signature stays readable and writable at all times. The only way back to an unlocked device is a bulk erase. A bulk erase walks every pattern word back to all ones, clears the lock, and, when `ERASE_SIG` is 1, also sets the signature to all ones.

The controller is a four-state machine. `ST_IDLE` accepts a command and moves to `ST_EXEC`. `ST_EXEC` carries out a single-cycle command and returns to `ST_IDLE`, or, for an erase, moves to `ST_WIPE`. `ST_WIPE` clears one word per cycle and moves to `ST_SEAL` after the last word. `ST_SEAL` clears the lock and the signature, then returns to `ST_IDLE`.

Top module: `sigvault_top`

## Requirements
- R1: After reset `busy`, `err`, `rd_valid` and `sig_tdo` are 0, every pattern word reads all ones, and the lock is clear.
- R2: `cmd_op` encodings are 0 none, 1 signature write, 2 signature readout, 3 pattern program, 4 pattern verify, 5 set lock, 6 bulk erase, 7 spare. A command is accepted on a rising edge where `cmd_valid` is 1 and `busy` is 0. For every opcode except 6, `busy` is then high for exactly one cycle. `cmd_valid` is ignored while `busy` is high.
- R3: After a signature readout, `sig_tdo` presents signature bit 0. Each cycle with `sig_shift_en` high advances to the next bit, and zeros follow bit 31.
- R4: When unlocked, a verify raises `rd_valid` for the one busy cycle, with `rd_data` equal to the word last programmed at `cmd_addr`.
- R5: When locked, a verify raises `rd_valid` and `err` together for one cycle, and `rd_data` is zero.
- R6: When locked, a program raises `err` for one cycle, and `rd_valid` stays 0.
- R7: Signature write and readout work the same whether or not the lock is set.
- R8: A bulk erase keeps `busy` high for DEPTH+2 cycles. Afterwards every pattern word reads all ones and the lock is clear.
- R9: With `ERASE_SIG`=1 a bulk erase sets the signature to all ones. With `ERASE_SIG`=0 it leaves the signature unchanged.
- R10: A set-lock while already locked, an opcode 7 and an opcode 0 raise no error and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Command opcode |
| cmd_addr | input | AW | Pattern word address |
| cmd_pat | input | WIDTH | Pattern word to program |
| cmd_sig | input | 32 | Signature value to write |
| busy | output | 1 | Command in progress |
| err | output | 1 | One-cycle refusal pulse |
| rd_valid | output | 1 | Verify data valid |
| rd_data | output | WIDTH | Verify data, zero when refused |
| sig_shift_en | input | 1 | Advance the signature shift |
| sig_tdo | output | 1 | Serial signature bit |

## Verification
The bench builds the block with DEPTH=8 and WIDTH=16, so each erase walk lasts only ten busy cycles. This makes it practical to count every erase cycle and to inject ignored commands while the walk runs. A second instance with `ERASE_SIG`=0 receives the same stimulus as the default instance. Comparing the two shows both erase variants side by side on one signature value that was written while the lock was set.

// File: rtl/sigvault_pkg.sv
package sigvault_pkg;

    localparam int SIG_W = 32;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_SIG_WR   = 3'd1,
        OP_SIG_RD   = 3'd2,
        OP_PAT_PROG = 3'd3,
        OP_PAT_VFY  = 3'd4,
        OP_LOCK     = 3'd5,
        OP_ERASE    = 3'd6,
        OP_SPARE    = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXEC,
        ST_WIPE,
        ST_SEAL
    } st_e;

endpackage

// File: rtl/sigvault_shifter.sv
module sigvault_shifter
    import sigvault_pkg::*;
#(
    parameter bit ERASE_SIG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SIG_W-1:0] wr_data,
    input  logic             load,
    input  logic             shift_en,
    input  logic             wipe,
    output logic             tdo
);

    logic [SIG_W-1:0] sig_q;
    logic [SIG_W-1:0] sh_q;
    logic             wipe_en;

    generate
        if (ERASE_SIG) begin : g_wipe
            assign wipe_en = wipe;
        end else begin : g_keep
            assign wipe_en = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_q <= '1;
        end else if (wr_en) begin
            sig_q <= wr_data;
        end else if (wipe_en) begin
            sig_q <= '1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= sig_q;
        end else if (shift_en) begin
            sh_q <= {1'b0, sh_q[SIG_W-1:1]};
        end
    end

    assign tdo = sh_q[0];

endmodule

// File: rtl/sigvault_store.sv
module sigvault_store #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '1;
            end
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/sigvault_ctrl.sv
module sigvault_ctrl
    import sigvault_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int WIDTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [AW-1:0]    cmd_addr,
    input  logic [WIDTH-1:0] cmd_pat,
    input  logic [SIG_W-1:0] cmd_sig,
    output logic             busy,
    output logic             err,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_data,
    output logic             lock,
    output logic             mem_we,
    output logic [AW-1:0]    mem_waddr,
    output logic [WIDTH-1:0] mem_wdata,
    output logic [AW-1:0]    mem_raddr,
    input  logic [WIDTH-1:0] mem_rdata,
    output logic             sig_wr,
    output logic [SIG_W-1:0] sig_wdata,
    output logic             sig_load,
    output logic             sig_wipe
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    st_e              state_q, state_d;
    op_e              op_q;
    logic [AW-1:0]    addr_q;
    logic [WIDTH-1:0] pat_q;
    logic [SIG_W-1:0] sig_q;
    logic [AW-1:0]    cnt_q;
    logic             lock_q;
    logic             refused;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_valid) state_d = ST_EXEC;
            ST_EXEC: state_d = (op_q == OP_ERASE) ? ST_WIPE : ST_IDLE;
            ST_WIPE: if (cnt_q == LAST) state_d = ST_SEAL;
            ST_SEAL: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_NONE;
            addr_q  <= '0;
            pat_q   <= '0;
            sig_q   <= '0;
            cnt_q   <= '0;
            lock_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && cmd_valid) begin
                op_q   <= op_e'(cmd_op);
                addr_q <= cmd_addr;
                pat_q  <= cmd_pat;
                sig_q  <= cmd_sig;
            end
            if (state_q == ST_EXEC) begin
                cnt_q <= '0;
            end else if (state_q == ST_WIPE) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (state_q == ST_EXEC && op_q == OP_LOCK) begin
                lock_q <= 1'b1;
            end else if (state_q == ST_SEAL) begin
                lock_q <= 1'b0;
            end
        end
    end

    assign refused = lock_q && (op_q == OP_PAT_PROG || op_q == OP_PAT_VFY);

    // outputs
    always_comb begin
        busy      = 1'b1;
        err       = 1'b0;
        rd_valid  = 1'b0;
        rd_data   = '0;
        mem_we    = 1'b0;
        mem_waddr = addr_q;
        mem_wdata = pat_q;
        sig_wr    = 1'b0;
        sig_load  = 1'b0;
        sig_wipe  = 1'b0;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_EXEC: begin
                err      = refused;
                rd_valid = (op_q == OP_PAT_VFY);
                if (op_q == OP_PAT_VFY && !refused) rd_data = mem_rdata;
                mem_we   = (op_q == OP_PAT_PROG) && !refused;
                sig_wr   = (op_q == OP_SIG_WR);
                sig_load = (op_q == OP_SIG_RD);
            end
            ST_WIPE: begin
                mem_we    = 1'b1;
                mem_waddr = cnt_q;
                mem_wdata = '1;
            end
            ST_SEAL: sig_wipe = 1'b1;
            default: busy = 1'b1;
        endcase
    end

    assign mem_raddr = addr_q;
    assign sig_wdata = sig_q;
    assign lock      = lock_q;

endmodule

// File: rtl/sigvault_top.sv
module sigvault_top
    import sigvault_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int WIDTH = 16,
    parameter bit ERASE_SIG = 1'b1,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [AW-1:0]    cmd_addr,
    input  logic [WIDTH-1:0] cmd_pat,
    input  logic [31:0]      cmd_sig,
    output logic             busy,
    output logic             err,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_data,
    input  logic             sig_shift_en,
    output logic             sig_tdo
);

    logic             lock_w;
    logic             mem_we;
    logic [AW-1:0]    mem_waddr;
    logic [WIDTH-1:0] mem_wdata;
    logic [AW-1:0]    mem_raddr;
    logic [WIDTH-1:0] mem_rdata;
    logic             sig_wr;
    logic [SIG_W-1:0] sig_wdata;
    logic             sig_load;
    logic             sig_wipe;

    sigvault_ctrl #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_pat(cmd_pat), .cmd_sig(cmd_sig),
        .busy(busy), .err(err), .rd_valid(rd_valid), .rd_data(rd_data),
        .lock(lock_w),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
        .sig_wr(sig_wr), .sig_wdata(sig_wdata), .sig_load(sig_load),
        .sig_wipe(sig_wipe)
    );

    sigvault_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(mem_raddr), .rdata(mem_rdata)
    );

    sigvault_shifter #(.ERASE_SIG(ERASE_SIG)) u_sig (
        .clk(clk), .rst_n(rst_n),
        .wr_en(sig_wr), .wr_data(sig_wdata), .load(sig_load),
        .shift_en(sig_shift_en), .wipe(sig_wipe), .tdo(sig_tdo)
    );

endmodule

// File: rtl/sigvault_chk.sv
module sigvault_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             busy,
    input logic             err,
    input logic             rd_valid,
    input logic [WIDTH-1:0] rd_data,
    input logic             lock
);

    AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid) |=> busy); // R2

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!err && !rd_valid)); // R2

    AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R4

    AST_REFUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (err && rd_valid) |-> (rd_data == '0)); // R5

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err); // R5

    AST_ERR_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> lock); // R6

    AST_LOCK_CLEARS_IN_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock) |-> $past(busy)); // R8

endmodule

bind sigvault_top sigvault_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy),
    .err(err), .rd_valid(rd_valid), .rd_data(rd_data), .lock(lock_w)
);

// File: tb/tb_sigvault_top.sv
`timescale 1ns/1ps
module tb_sigvault_top;

    localparam int DEPTH = 8;
    localparam int WIDTH = 16;
    localparam int AW = $clog2(DEPTH);
    localparam logic [2:0] C_NONE = 0, C_SWR = 1, C_SRD = 2, C_PROG = 3,
                           C_VFY = 4, C_LOCK = 5, C_ERASE = 6, C_SPARE = 7;

    logic clk = 0;
    logic rst_n = 0;
    logic cmd_valid = 0;
    logic [2:0] cmd_op = 0;
    logic [AW-1:0] cmd_addr = 0;
    logic [WIDTH-1:0] cmd_pat = 0;
    logic [31:0] cmd_sig = 0;
    logic sig_shift_en = 0;
    logic busy, err, rd_valid, sig_tdo;
    logic [WIDTH-1:0] rd_data;
    logic busy_k, err_k, rdv_k, tdo_k;
    logic [WIDTH-1:0] rdd_k;

    always #4 clk = ~clk;

    sigvault_top #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ERASE_SIG(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_pat(cmd_pat), .cmd_sig(cmd_sig),
        .busy(busy), .err(err), .rd_valid(rd_valid), .rd_data(rd_data),
        .sig_shift_en(sig_shift_en), .sig_tdo(sig_tdo));

    sigvault_top #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ERASE_SIG(1'b0)) dut_keep (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_pat(cmd_pat), .cmd_sig(cmd_sig),
        .busy(busy_k), .err(err_k), .rd_valid(rdv_k), .rd_data(rdd_k),
        .sig_shift_en(sig_shift_en), .sig_tdo(tdo_k));

    int checks = 0;
    int fails = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic [WIDTH-1:0] m_mem [DEPTH];
    logic [31:0] m_sig, m_sig_keep, m_sh, m_sh_keep;
    bit m_lock, m_first;
    int m_left;
    logic [2:0] m_op;
    logic [AW-1:0] m_addr;
    logic [WIDTH-1:0] m_pat;
    logic [31:0] m_sigw;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = '1;
            m_sig = '1; m_sig_keep = '1; m_sh = 0; m_sh_keep = 0;
            m_lock = 0; m_first = 0; m_left = 0; m_op = 0;
        end else begin
            if (m_left > 0 && m_first && m_op == C_SRD) begin
                m_sh = m_sig; m_sh_keep = m_sig_keep;
            end else if (sig_shift_en) begin
                m_sh = m_sh >> 1; m_sh_keep = m_sh_keep >> 1;
            end
            if (m_left > 0) begin
                if (m_first) begin
                    if (m_op == C_SWR) begin m_sig = m_sigw; m_sig_keep = m_sigw; end
                    if (m_op == C_PROG && !m_lock) m_mem[m_addr] = m_pat;
                    if (m_op == C_LOCK) m_lock = 1;
                end
                m_first = 0;
                m_left--;
                if (m_left == 0 && m_op == C_ERASE) begin
                    foreach (m_mem[i]) m_mem[i] = '1;
                    m_lock = 0;
                    m_sig = '1;
                end
            end else if (cmd_valid) begin
                m_op = cmd_op; m_addr = cmd_addr; m_pat = cmd_pat; m_sigw = cmd_sig;
                m_left = (cmd_op == C_ERASE) ? DEPTH + 2 : 1;
                m_first = 1;
            end
        end
    end

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            bit e_err, e_rdv;
            logic [WIDTH-1:0] e_rdd;
            e_err = m_first && m_lock && (m_op == C_PROG || m_op == C_VFY);
            e_rdv = m_first && m_op == C_VFY;
            e_rdd = (e_rdv && !m_lock) ? m_mem[m_addr] : '0;
            check(busy == (m_left > 0), "R2 busy vs model", busy, m_left > 0);
            check(err == e_err, "R5 err vs model", err, e_err);
            check(rd_valid == e_rdv, "R4 rd_valid vs model", rd_valid, e_rdv);
            check(rd_data == e_rdd, "R4 rd_data vs model", rd_data, e_rdd);
            check(sig_tdo == m_sh[0], "R3 sig_tdo vs model", sig_tdo, m_sh[0]);
            check(tdo_k == m_sh_keep[0], "R9 keep sig_tdo vs model", tdo_k, m_sh_keep[0]);
        end
    end

    logic c_err, c_rdv;
    logic [WIDTH-1:0] c_rdd;

    task automatic do_cmd(input logic [2:0] op, input logic [AW-1:0] a,
                          input logic [WIDTH-1:0] p, input logic [31:0] s);
        @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_pat = p; cmd_sig = s;
        @(negedge clk);
        cmd_valid = 0;
        c_err = err; c_rdv = rd_valid; c_rdd = rd_data;
        while (busy) @(negedge clk);
    endtask

    task automatic shift_out(output logic [31:0] v, output logic [31:0] vk, output bit tail_zero);
        for (int i = 0; i < 32; i++) begin
            v[i] = sig_tdo; vk[i] = tdo_k;
            sig_shift_en = 1;
            @(negedge clk);
        end
        tail_zero = (sig_tdo == 0);
        sig_shift_en = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        logic [31:0] v, vk;
        bit tz;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(!busy && !err && !rd_valid && !sig_tdo, "R1 outputs after reset",
              {busy, err, rd_valid, sig_tdo}, 0);
        do_cmd(C_VFY, 3, 0, 0);
        check(c_rdd == 16'hFFFF && !c_err, "R1 erased word after reset", c_rdd, 16'hFFFF);

        do_cmd(C_PROG, 3, 16'hA5C3, 0);
        do_cmd(C_PROG, 0, 16'h1234, 0);
        do_cmd(C_PROG, 7, 16'h0F0F, 0);
        do_cmd(C_VFY, 3, 0, 0);
        check(c_rdv && c_rdd == 16'hA5C3, "R4 verify word 3", c_rdd, 16'hA5C3);
        do_cmd(C_VFY, 0, 0, 0);
        check(c_rdd == 16'h1234, "R4 verify word 0", c_rdd, 16'h1234);
        do_cmd(C_VFY, 7, 0, 0);
        check(c_rdd == 16'h0F0F, "R4 verify word 7", c_rdd, 16'h0F0F);

        do_cmd(C_SWR, 0, 0, 32'hDEADBEEF);
        do_cmd(C_SRD, 0, 0, 0);
        shift_out(v, vk, tz);
        check(v == 32'hDEADBEEF, "R3 signature shifted LSB first", v, 32'hDEADBEEF);
        check(tz, "R3 zero after bit 31", !tz, 0);

        do_cmd(C_LOCK, 0, 0, 0);
        do_cmd(C_VFY, 3, 0, 0);
        check(c_err && c_rdv && c_rdd == 0, "R5 locked verify refused",
              {c_err, c_rdv, c_rdd}, {2'b11, 16'h0});
        do_cmd(C_PROG, 3, 16'h5555, 0);
        check(c_err && !c_rdv, "R6 locked program refused", {c_err, c_rdv}, 2'b10);

        do_cmd(C_SWR, 0, 0, 32'h0BADF00D);
        do_cmd(C_SRD, 0, 0, 0);
        shift_out(v, vk, tz);
        check(v == 32'h0BADF00D, "R7 signature while locked", v, 32'h0BADF00D);

        do_cmd(C_LOCK, 0, 0, 0);
        check(!c_err, "R10 relock no error", c_err, 0);
        do_cmd(C_SPARE, 0, 0, 0);
        check(!c_err, "R10 spare opcode no error", c_err, 0);
        do_cmd(C_NONE, 0, 0, 0);
        check(!c_err, "R10 opcode 0 no error", c_err, 0);
        do_cmd(C_VFY, 3, 0, 0);
        check(c_err && c_rdd == 0, "R10 lock unchanged", c_err, 1);

        // erase with commands offered while busy
        @(negedge clk);
        cmd_valid = 1; cmd_op = C_ERASE;
        @(negedge clk);
        n = busy ? 1 : 0;
        cmd_op = C_PROG; cmd_addr = 5; cmd_pat = 16'h0000;
        repeat (3) begin @(negedge clk); if (busy) n++; end
        cmd_valid = 0;
        while (busy) begin @(negedge clk); if (busy) n++; end
        check(n == DEPTH + 2, "R8 erase busy length", n, DEPTH + 2);
        do_cmd(C_VFY, 5, 0, 0);
        check(c_rdd == 16'hFFFF, "R2 command ignored while busy", c_rdd, 16'hFFFF);
        do_cmd(C_VFY, 3, 0, 0);
        check(!c_err && c_rdd == 16'hFFFF, "R8 erased and unlocked", c_rdd, 16'hFFFF);
        do_cmd(C_PROG, 2, 16'hBEEF, 0);
        do_cmd(C_VFY, 2, 0, 0);
        check(c_rdd == 16'hBEEF, "R8 program after erase", c_rdd, 16'hBEEF);

        do_cmd(C_SRD, 0, 0, 0);
        shift_out(v, vk, tz);
        check(v == 32'hFFFFFFFF, "R9 signature erased", v, 32'hFFFFFFFF);
        check(vk == 32'h0BADF00D, "R9 signature kept", vk, 32'h0BADF00D);

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule